// File: doc/BRIEF.md
# Configuration Image Loader with Checksum Restore

The block copies a 64-byte configuration image from a byte-wide nonvolatile store into a local register file. Reads go out one byte at a time through a request/acknowledge port. While reading, the block keeps an 8-bit running sum. When the last byte arrives, it compares that sum with the last byte to decide whether the image is intact.

If the image is corrupt, the block walks the store once and writes a built-in default image. It writes only the locations whose stored byte differs from the default. It then reads the whole image a second time. That second read is final, whatever its checksum.

A store access that gets no acknowledge within a fixed number of cycles aborts the whole operation. Once a load completes, the block checks a revision byte. Software or downstream logic reads the loaded bytes through a combinational read port. It takes the outcome from a one-cycle done pulse and a set of held status flags.

Top module: `cfg_loader`

## Requirements
- R1: After a start, the block reads addresses 0, 1, ..., 63 in ascending order. It keeps one request outstanding at a time and holds `mem_req_o`, `mem_we_o` and `mem_addr_o` stable until `mem_ack_i` is sampled high.
- R2: A load is valid when the modulo-256 sum of bytes 0 to 62 equals byte 63. `cksum_ok_o` reports this for the last read pass.
- R3: The default image has byte 11 = 0x01 and byte a = a XOR 0x5A for every other a from 0 to 62. Byte 63 of the default image is the modulo-256 sum of default bytes 0 to 62.
- R4: On a checksum mismatch in the first pass, addresses 0 to 63 are visited in ascending order. A write of the default byte is issued only where the default byte differs from the byte just read.
- R5: After a restore, `restored_o` is 1 and the 64-byte read is repeated exactly once. A mismatch in that second pass ends the run with `cksum_ok_o` = 0 and no further writes.
- R6: If a request sees no acknowledge for TIMEOUT (default 16) consecutive cycles, the request is dropped and the run ends. `error_o` = 1 and `cksum_ok_o` = 0.
- R7: Each run that ends without a timeout sets `bad_rev_o` to 1 exactly when loaded byte 11 is not 0x01.
- R8: `busy_o` rises the cycle after start is accepted and falls after the single-cycle `done_o` pulse. Status flags hold their values until the next accepted start.
- R9: `start_i` has no effect while `busy_o` is high.
- R10: `rd_data_o` combinationally shows the register-file byte at `rd_addr_i`. After a completed run, this equals the image read in the last pass.
- R11: During reset, all status outputs and `mem_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a load when idle |
| rd_addr_i | input | 6 | Register-file read address |
| rd_data_o | output | 8 | Register-file read data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| cksum_ok_o | output | 1 | Last read pass had a matching checksum |
| restored_o | output | 1 | Default image was written this run |
| error_o | output | 1 | Run aborted by an acknowledge timeout |
| bad_rev_o | output | 1 | Revision byte not 0x01 |
| mem_req_o | output | 1 | Store access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 6 | Store byte address |
| mem_wdata_o | output | 8 | Store write data |
| mem_ack_i | input | 1 | Store acknowledge, one cycle |
| mem_rdata_i | input | 8 | Store read data, valid with acknowledge |

## Verification
A request appears on the store port one cycle after the controller issues it, so each new access is compared against the bench's expected address and data queue at the first falling edge on which `mem_req_o` is high. A stalled access is expected to stay visible for exactly TIMEOUT falling edges. `done_o` is asserted in the cycle after the final acknowledge or timeout, and the status flags are already settled in that cycle, so they are sampled at that falling edge and again one cycle later to confirm that they hold. Register-file contents are read back through the combinational port a fraction of a cycle after each address change.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_GO,
    ST_RD_WAIT,
    ST_WR_CHK,
    ST_WR_WAIT,
    ST_FIN
  } ld_state_e;
endpackage

// File: rtl/cfg_dflt_gen.sv
module cfg_dflt_gen #(
  parameter int                NUM_BYTES = 64,
  parameter int                DATA_W    = 8,
  parameter int                REV_OFS   = 11,
  parameter logic [DATA_W-1:0] REV_VAL   = 1,
  parameter logic [DATA_W-1:0] SEED      = 'h5A,
  localparam int               AW        = $clog2(NUM_BYTES)
) (
  input  logic [AW-1:0]     addr_i,
  output logic [DATA_W-1:0] data_o
);
  function automatic logic [DATA_W-1:0] body(input int a);
    if (a == REV_OFS) return REV_VAL;
    return DATA_W'(a) ^ SEED;
  endfunction

  function automatic logic [DATA_W-1:0] total();
    logic [DATA_W-1:0] s;
    s = '0;
    for (int i = 0; i < NUM_BYTES - 1; i++) s = s + body(i);
    return s;
  endfunction

  localparam logic [DATA_W-1:0] CSUM = total();

  always_comb begin
    if (int'(addr_i) == NUM_BYTES - 1) data_o = CSUM;
    else                               data_o = body(int'(addr_i));
  end
endmodule

// File: rtl/cfg_bus_ctl.sv
module cfg_bus_ctl #(
  parameter int  AW      = 6,
  parameter int  DATA_W  = 8,
  parameter int  TIMEOUT = 16,
  localparam int CW      = $clog2(TIMEOUT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ok_o,
  output logic              tmo_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic              req_q, we_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [CW-1:0]     cnt_q;
  logic              last_wait;

  assign last_wait = (cnt_q == CW'(TIMEOUT - 1));
  assign ok_o      = req_q & mem_ack_i;
  assign tmo_o     = req_q & ~mem_ack_i & last_wait;
  assign rdata_o   = mem_rdata_i;

  assign mem_req_o   = req_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      cnt_q   <= '0;
    end else if (go_i && !req_q) begin
      req_q   <= 1'b1;
      we_q    <= we_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      cnt_q   <= '0;
    end else if (ok_o || tmo_o) begin
      req_q <= 1'b0;
      cnt_q <= '0;
    end else if (req_q) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // R1
  single_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !req_q);
  // R1
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && !last_wait) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  // R6
  wait_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(TIMEOUT));
  // R6
  tmo_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |=> !mem_req_o);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int  NUM_BYTES = 64,
  parameter int  DATA_W    = 8,
  parameter int  REV_OFS   = 11,
  localparam int AW        = $clog2(NUM_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [AW-1:0]     raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o,
  output logic [DATA_W-1:0] rev_o
);
  logic [NUM_BYTES*DATA_W-1:0] flat;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    logic [DATA_W-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 byte_q <= '0;
      else if (we_i && (waddr_i == AW'(g)))        byte_q <= wdata_i;
    end
    assign flat[g*DATA_W +: DATA_W] = byte_q;
  end

  assign rdata_a_o = flat[raddr_a_i*DATA_W +: DATA_W];
  assign rdata_b_o = flat[raddr_b_i*DATA_W +: DATA_W];
  assign rev_o     = flat[REV_OFS*DATA_W +: DATA_W];
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_pkg::*;
#(
  parameter int                NUM_BYTES = 64,
  parameter int                DATA_W    = 8,
  parameter int                TIMEOUT   = 16,
  parameter int                REV_OFS   = 11,
  parameter logic [DATA_W-1:0] REV_VAL   = 1,
  parameter logic [DATA_W-1:0] SEED      = 'h5A,
  localparam int               AW        = $clog2(NUM_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              cksum_ok_o,
  output logic              restored_o,
  output logic              error_o,
  output logic              bad_rev_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam logic [AW-1:0] LAST = AW'(NUM_BYTES - 1);

  ld_state_e         state_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] sum_q;
  logic              restored_q, cksum_ok_q, error_q, bad_rev_q;

  logic              bus_go, bus_we, bus_ok, bus_tmo;
  logic [DATA_W-1:0] bus_rdata, dflt_byte, held_byte, rev_byte;
  logic              differs, rf_we;

  cfg_dflt_gen #(
    .NUM_BYTES(NUM_BYTES), .DATA_W(DATA_W), .REV_OFS(REV_OFS),
    .REV_VAL(REV_VAL), .SEED(SEED)
  ) u_dflt (
    .addr_i(addr_q),
    .data_o(dflt_byte)
  );

  cfg_regfile #(
    .NUM_BYTES(NUM_BYTES), .DATA_W(DATA_W), .REV_OFS(REV_OFS)
  ) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (rf_we),
    .waddr_i  (addr_q),
    .wdata_i  (bus_rdata),
    .raddr_a_i(rd_addr_i),
    .rdata_a_o(rd_data_o),
    .raddr_b_i(addr_q),
    .rdata_b_o(held_byte),
    .rev_o    (rev_byte)
  );

  cfg_bus_ctl #(
    .AW(AW), .DATA_W(DATA_W), .TIMEOUT(TIMEOUT)
  ) u_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (bus_go),
    .we_i       (bus_we),
    .addr_i     (addr_q),
    .wdata_i    (dflt_byte),
    .ok_o       (bus_ok),
    .tmo_o      (bus_tmo),
    .rdata_o    (bus_rdata),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_ack_i  (mem_ack_i),
    .mem_rdata_i(mem_rdata_i)
  );

  assign differs = (held_byte != dflt_byte);
  assign bus_we  = (state_q == ST_WR_CHK);
  assign bus_go  = (state_q == ST_RD_GO) || ((state_q == ST_WR_CHK) && differs);
  assign rf_we   = (state_q == ST_RD_WAIT) && bus_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      sum_q      <= '0;
      restored_q <= 1'b0;
      cksum_ok_q <= 1'b0;
      error_q    <= 1'b0;
      bad_rev_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          addr_q     <= '0;
          sum_q      <= '0;
          restored_q <= 1'b0;
          cksum_ok_q <= 1'b0;
          error_q    <= 1'b0;
          bad_rev_q  <= 1'b0;
          state_q    <= ST_RD_GO;
        end
        ST_RD_GO: state_q <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (bus_tmo) begin
            error_q <= 1'b1;
            state_q <= ST_FIN;
          end else if (bus_ok) begin
            if (addr_q != LAST) begin
              sum_q   <= sum_q + bus_rdata;
              addr_q  <= addr_q + AW'(1);
              state_q <= ST_RD_GO;
            end else if (sum_q == bus_rdata || restored_q) begin
              // final pass: checksum either matched or no retry remains
              cksum_ok_q <= (sum_q == bus_rdata);
              bad_rev_q  <= (rev_byte != REV_VAL);
              state_q    <= ST_FIN;
            end else begin
              addr_q  <= '0;
              state_q <= ST_WR_CHK;
            end
          end
        end
        ST_WR_CHK: begin
          if (differs) begin
            state_q <= ST_WR_WAIT;
          end else if (addr_q == LAST) begin
            addr_q     <= '0;
            sum_q      <= '0;
            restored_q <= 1'b1;
            state_q    <= ST_RD_GO;
          end else begin
            addr_q <= addr_q + AW'(1);
          end
        end
        ST_WR_WAIT: begin
          if (bus_tmo) begin
            error_q <= 1'b1;
            state_q <= ST_FIN;
          end else if (bus_ok) begin
            if (addr_q == LAST) begin
              addr_q     <= '0;
              sum_q      <= '0;
              restored_q <= 1'b1;
              state_q    <= ST_RD_GO;
            end else begin
              addr_q  <= addr_q + AW'(1);
              state_q <= ST_WR_CHK;
            end
          end
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_FIN);
  assign cksum_ok_o = cksum_ok_q;
  assign restored_o = restored_q;
  assign error_o    = error_q;
  assign bad_rev_o  = bad_rev_q;

  // R1
  read_ascend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_WAIT && bus_ok && addr_q != LAST) |=>
      (addr_q == $past(addr_q) + AW'(1)));
  // R4
  write_differs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_wdata_o != held_byte));
  // R5
  single_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restored_q |-> !(state_q inside {ST_WR_CHK, ST_WR_WAIT}));
  // R6
  err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !cksum_ok_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: tb/test_cfg_loader.sv
module test_cfg_loader;
  localparam int CLK_PERIOD = 10;
  localparam int NB         = 64;
  localparam int TMO        = 16;
  localparam int REV_AT     = 11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [5:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy, done, ck_ok, restored, err, bad_rev;
  logic       mem_req, mem_we;
  logic [5:0] mem_addr;
  logic [7:0] mem_wdata;
  logic       mem_ack = 1'b0;
  logic [7:0] mem_rdata = '0;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] store [NB];
  int stall_a = -1;
  bit stall_w = 1'b0;
  int drop_a = -1;
  int stall_cnt = 0;
  bit seen = 1'b0;
  int lat = 0;
  int exp_rd[$];
  int exp_wa[$];
  int exp_wd[$];

  cfg_loader i_cfg_loader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .busy_o(busy), .done_o(done), .cksum_ok_o(ck_ok),
    .restored_o(restored), .error_o(err), .bad_rev_o(bad_rev),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R3 default image, computed from the requirement text
  function automatic int dflt_body(int a);
    if (a == REV_AT) return 1;
    return (a ^ 'h5A) & 255;
  endfunction

  function automatic int dflt(int a);
    int s;
    if (a != NB - 1) return dflt_body(a);
    s = 0;
    for (int i = 0; i < NB - 1; i++) s += dflt_body(i);
    return s % 256;
  endfunction

  function automatic bit csum_good(input logic [7:0] img [NB]);
    int s;
    s = 0;
    for (int i = 0; i < NB - 1; i++) s += int'(img[i]);
    return (s % 256) == int'(img[NB-1]);
  endfunction

  function automatic int sum_low(input logic [7:0] img [NB]);
    int s;
    s = 0;
    for (int i = 0; i < NB - 1; i++) s += int'(img[i]);
    return s % 256;
  endfunction

  // store model with random acknowledge latency and per-access checks
  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (!mem_req) begin
      seen = 1'b0;
    end else begin
      if (!seen) begin
        seen = 1'b1;
        lat = $urandom_range(0, 3);
        if (mem_we) begin
          if (exp_wa.size() == 0) chk("R4 unexpected write", int'(mem_addr), -1);
          else begin
            chk("R4 write address", int'(mem_addr), exp_wa.pop_front());
            chk("R3 write data", int'(mem_wdata), exp_wd.pop_front());
          end
        end else begin
          if (exp_rd.size() == 0) chk("R1 unexpected read", int'(mem_addr), -1);
          else chk("R1 read address", int'(mem_addr), exp_rd.pop_front());
        end
      end
      if (int'(mem_addr) == stall_a && mem_we == stall_w) begin
        stall_cnt++;
      end else if (lat == 0) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          if (int'(mem_addr) != drop_a) store[mem_addr] = mem_wdata;
        end else begin
          mem_rdata = store[mem_addr];
        end
      end else begin
        lat--;
      end
    end
  end

  task automatic run_case(string tag, int s_a, bit s_w, int d_a, bit extra_start);
    logic [7:0] img [NB];
    bit e_ok, e_rest, e_err, e_bad;
    int n;
    e_ok = 0; e_rest = 0; e_err = 0; e_bad = 0;
    for (int a = 0; a < NB; a++) img[a] = store[a];
    stall_a = s_a; stall_w = s_w; drop_a = d_a; stall_cnt = 0;
    exp_rd.delete(); exp_wa.delete(); exp_wd.delete();
    for (int a = 0; a < NB && !e_err; a++) begin
      exp_rd.push_back(a);
      if (!s_w && a == s_a) e_err = 1;
    end
    if (!e_err) begin
      if (csum_good(img)) begin
        e_ok = 1;
        e_bad = (img[REV_AT] != 8'd1);
      end else begin
        for (int a = 0; a < NB && !e_err; a++) begin
          if (int'(img[a]) != dflt(a)) begin
            exp_wa.push_back(a);
            exp_wd.push_back(dflt(a));
            if (s_w && a == s_a) e_err = 1;
            else if (a != d_a) img[a] = 8'(dflt(a));
          end
        end
        if (!e_err) begin
          e_rest = 1;
          for (int a = 0; a < NB; a++) exp_rd.push_back(a);
          e_ok = csum_good(img);
          e_bad = (img[REV_AT] != 8'd1);
        end
      end
    end
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk({tag, " R8 busy after start"}, int'(busy), 1);
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      start = (extra_start && n == 25);  // R9 start while busy
    end
    start = 1'b0;
    chk({tag, " R8 done pulse"}, int'(done), 1);
    chk({tag, " R2 cksum_ok"}, int'(ck_ok), int'(e_ok));
    chk({tag, " R5 restored"}, int'(restored), int'(e_rest));
    chk({tag, " R6 error"}, int'(err), int'(e_err));
    chk({tag, " R7 bad_rev"}, int'(bad_rev), int'(e_bad));
    chk({tag, " R1 reads outstanding"}, exp_rd.size(), 0);
    chk({tag, " R4 writes outstanding"}, exp_wa.size(), 0);
    if (s_a >= 0) chk({tag, " R6 stall cycles"}, stall_cnt, TMO);
    @(negedge clk);
    chk({tag, " R8 done one cycle"}, int'(done), 0);
    chk({tag, " R8 busy low"}, int'(busy), 0);
    chk({tag, " R8 status held"}, int'(ck_ok), int'(e_ok));
    if (!e_err) begin
      for (int a = 0; a < NB; a++) begin
        rd_addr = 6'(a);
        #1;
        chk({tag, " R10 readback"}, int'(rd_data), int'(img[a]));
        chk({tag, " R4 store content"}, int'(store[a]), int'(img[a]));
      end
    end
    stall_a = -1; drop_a = -1;
    repeat (2) @(negedge clk);
  endtask

  task automatic load_default();
    for (int a = 0; a < NB; a++) store[a] = 8'(dflt(a));
  endtask

  task automatic load_random(bit good, int rev);
    logic [7:0] img [NB];
    for (int a = 0; a < NB; a++) img[a] = 8'($urandom_range(0, 255));
    if (rev >= 0) img[REV_AT] = 8'(rev);
    img[NB-1] = 8'(sum_low(img) + (good ? 0 : 1));
    for (int a = 0; a < NB; a++) store[a] = img[a];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    load_default();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", int'(busy), 0);
    chk("R11 done", int'(done), 0);
    chk("R11 error", int'(err), 0);
    chk("R11 cksum_ok", int'(ck_ok), 0);
    chk("R11 restored", int'(restored), 0);
    chk("R11 mem_req", int'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    load_default();
    run_case("default", -1, 1'b0, -1, 1'b0);

    load_random(1'b1, 3);
    run_case("valid bad rev", -1, 1'b0, -1, 1'b0);

    load_random(1'b0, -1);
    run_case("corrupt", -1, 1'b0, -1, 1'b0);

    load_default();
    store[5]  = store[5] ^ 8'h01;
    store[40] = store[40] ^ 8'h02;
    run_case("two bytes off", -1, 1'b0, -1, 1'b0);

    load_default();
    store[7]  = store[7] ^ 8'hFF;
    store[30] = store[30] ^ 8'h10;
    run_case("write dropped", -1, 1'b0, 7, 1'b0);

    load_default();
    run_case("read stall", 20, 1'b0, -1, 1'b0);

    load_random(1'b0, -1);
    store[3] = 8'(dflt(3) ^ 'h33);
    run_case("write stall", 3, 1'b1, -1, 1'b0);

    load_random(1'b0, 1);
    run_case("start while busy", -1, 1'b0, -1, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule